// File: doc/BRIEF.md
# Serial Port Interrupt Request Controller

This block turns the level status flags of a FIFO-buffered serial port into request lines. It watches six flags (transmit FIFO empty, receive FIFO full, data ready, receive error, break and overrun) and combines them with three enable bits, an operating-mode input and two DMA steering selects. It produces four CPU interrupt lines (transmit, receive, receive error, break/overrun), two DMA request lines (transmit and receive) and a 3-bit code naming the highest-priority request headed for the CPU.

The receive-error and break/overrun lines have their own enable so that software can turn off receive-data interrupts and still hear about line faults. The transmit and receive requests can each be steered to a DMA engine, which then keeps the matching CPU line quiet. The data-ready flag only counts when the port runs asynchronously. Every output is registered, so a flag change shows up one clock later.

Top module: `sci_req_ctrl`

## Requirements
- R1: `txReq` is 1 one cycle after a cycle in which `txIntEn`=1, `txEmpty`=1 and `txToDma`=0; otherwise it is 0.
- R2: The receive request is active one cycle after a cycle in which `rxIntEn`=1 and either `rxFull`=1 or (`dataReady`=1 and `asyncMode`=1).
- R3: When `asyncMode`=0 (clocked mode), `dataReady` has no effect on `rxReq` or `rxDmaReq`.
- R4: With `rxIntEn`=0 and `errIntEn`=1, `errReq` and `brkReq` follow their flags while `rxReq` and `rxDmaReq` stay 0.
- R5: `brkReq` is raised by either `breakDet` or `overrun`; `errReq` is raised by `rxError`. Both need the error path enabled (`rxIntEn`=1 or `errIntEn`=1).
- R6: With `rxIntEn`=1, `errReq` and `brkReq` follow their flags even when `errIntEn`=0.
- R7: With `txToDma`=1 the transmit request appears on `txDmaReq` and `txReq` stays 0; with `rxToDma`=1 the receive request appears on `rxDmaReq` and `rxReq` stays 0. Error and break requests never go to DMA.
- R8: `topSource` is 0 when no CPU line is active, else 1 for break/overrun, 2 for receive error, 3 for receive data, 4 for transmit, giving the highest active source in that order; DMA-routed requests are not counted.
- R9: A synchronous active-high `rst` drives all outputs to 0 at the next clock edge, whatever the inputs.
- R10: Every output changes exactly one clock after the inputs that cause it and holds no older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txEmpty | input | 1 | Transmit FIFO empty flag |
| rxFull | input | 1 | Receive FIFO full flag |
| dataReady | input | 1 | Receive data ready flag |
| rxError | input | 1 | Receive error flag |
| breakDet | input | 1 | Break condition flag |
| overrun | input | 1 | Overrun error flag |
| txIntEn | input | 1 | Transmit request enable |
| rxIntEn | input | 1 | Receive request enable (also enables error and break) |
| errIntEn | input | 1 | Receive-error and break request enable |
| asyncMode | input | 1 | 1 = asynchronous, 0 = clocked mode |
| txToDma | input | 1 | Steer transmit request to DMA |
| rxToDma | input | 1 | Steer receive request to DMA |
| txReq | output | 1 | Transmit interrupt request to CPU |
| rxReq | output | 1 | Receive interrupt request to CPU |
| errReq | output | 1 | Receive-error interrupt request |
| brkReq | output | 1 | Break/overrun interrupt request |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| topSource | output | 3 | Highest-priority CPU source code (0 none) |

## Verification
The assertions take the flags, enables and steering selects to be synchronous levels that are stable across each clock edge, and take `rst` to be held high at the first edge so the outputs start from a known state. The bench changes every input only on the falling edge and holds reset for the opening cycles, so each rising edge sees one settled input vector. Stimulus walks the enable, mode and steering combinations so that each gating rule, including the error path staying alive with receive interrupts off, is hit both with and without the flags that it should ignore.

// File: rtl/sci_req_pkg.sv
package sci_req_pkg;
  localparam int NUM_SRC = 4;
  localparam int CODE_W = $clog2(NUM_SRC + 1);

  // Priority index inside the CPU request vector: 0 is highest.
  localparam int IDX_BRK = 0;
  localparam int IDX_ERR = 1;
  localparam int IDX_RX  = 2;
  localparam int IDX_TX  = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_BRK  = 3'd1,
    SRC_ERR  = 3'd2,
    SRC_RX   = 3'd3,
    SRC_TX   = 3'd4
  } src_code_e;

  typedef struct packed {
    logic brkCpu;
    logic errCpu;
    logic rxCpu;
    logic txCpu;
    logic rxDma;
    logic txDma;
  } req_strobes_t;
endpackage

// File: rtl/sci_req_gate.sv
module sci_req_gate
  import sci_req_pkg::*;
(
  input  logic txEmpty,
  input  logic rxFull,
  input  logic dataReady,
  input  logic rxError,
  input  logic breakDet,
  input  logic overrun,
  input  logic txIntEn,
  input  logic rxIntEn,
  input  logic errIntEn,
  input  logic asyncMode,
  input  logic txToDma,
  input  logic rxToDma,
  output req_strobes_t strobes
);
  logic txPending;
  logic rxPending;
  logic errPathOn;
  logic rxDataSeen;

  always_comb begin
    // Data-ready is only meaningful in asynchronous mode.
    rxDataSeen = rxFull | (asyncMode & dataReady);
    txPending  = txIntEn & txEmpty;
    rxPending  = rxIntEn & rxDataSeen;
    // Line-fault requests survive with receive interrupts turned off.
    errPathOn  = rxIntEn | errIntEn;

    strobes.txCpu  = txPending & ~txToDma;
    strobes.txDma  = txPending & txToDma;
    strobes.rxCpu  = rxPending & ~rxToDma;
    strobes.rxDma  = rxPending & rxToDma;
    strobes.errCpu = errPathOn & rxError;
    strobes.brkCpu = errPathOn & (breakDet | overrun);
  end
endmodule

// File: rtl/sci_req_path.sv
module sci_req_path
  import sci_req_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  req_strobes_t strobes,
  output logic txReq,
  output logic rxReq,
  output logic errReq,
  output logic brkReq,
  output logic txDmaReq,
  output logic rxDmaReq,
  output logic [CODE_W-1:0] topSource
);
  logic [NUM_SRC-1:0] cpuVec;
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    cpuVec = '0;
    cpuVec[IDX_BRK] = strobes.brkCpu;
    cpuVec[IDX_ERR] = strobes.errCpu;
    cpuVec[IDX_RX]  = strobes.rxCpu;
    cpuVec[IDX_TX]  = strobes.txCpu;
  end

  // Scan from lowest to highest priority so the highest wins.
  always_comb begin
    codeNext = CODE_W'(SRC_NONE);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cpuVec[i]) codeNext = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txReq     <= 1'b0;
      rxReq     <= 1'b0;
      errReq    <= 1'b0;
      brkReq    <= 1'b0;
      txDmaReq  <= 1'b0;
      rxDmaReq  <= 1'b0;
      topSource <= '0;
    end else begin
      txReq     <= strobes.txCpu;
      rxReq     <= strobes.rxCpu;
      errReq    <= strobes.errCpu;
      brkReq    <= strobes.brkCpu;
      txDmaReq  <= strobes.txDma;
      rxDmaReq  <= strobes.rxDma;
      topSource <= codeNext;
    end
  end

  assert_brk_wins_R8: assert property (@(posedge clk) disable iff (rst)
    brkReq |-> topSource == CODE_W'(SRC_BRK));
  assert_err_over_rx_R8: assert property (@(posedge clk) disable iff (rst)
    (errReq && !brkReq) |-> topSource == CODE_W'(SRC_ERR));
  assert_none_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (topSource == CODE_W'(SRC_NONE)) |-> !(txReq || rxReq || errReq || brkReq));
  assert_tx_split_R7: assert property (@(posedge clk) disable iff (rst)
    !(txReq && txDmaReq));
endmodule

// File: rtl/sci_req_ctrl.sv
module sci_req_ctrl
  import sci_req_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic txEmpty,
  input  logic rxFull,
  input  logic dataReady,
  input  logic rxError,
  input  logic breakDet,
  input  logic overrun,
  input  logic txIntEn,
  input  logic rxIntEn,
  input  logic errIntEn,
  input  logic asyncMode,
  input  logic txToDma,
  input  logic rxToDma,
  output logic txReq,
  output logic rxReq,
  output logic errReq,
  output logic brkReq,
  output logic txDmaReq,
  output logic rxDmaReq,
  output logic [2:0] topSource
);
  req_strobes_t strobes;

  sci_req_gate uGate (
    .txEmpty(txEmpty), .rxFull(rxFull), .dataReady(dataReady),
    .rxError(rxError), .breakDet(breakDet), .overrun(overrun),
    .txIntEn(txIntEn), .rxIntEn(rxIntEn), .errIntEn(errIntEn),
    .asyncMode(asyncMode), .txToDma(txToDma), .rxToDma(rxToDma),
    .strobes(strobes)
  );

  sci_req_path uPath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .txReq(txReq), .rxReq(rxReq), .errReq(errReq), .brkReq(brkReq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .topSource(topSource)
  );

  assert_tx_raise_R1: assert property (@(posedge clk) disable iff (rst)
    (txIntEn && txEmpty && !txToDma) |=> txReq);
  assert_clocked_ignores_dr_R3: assert property (@(posedge clk) disable iff (rst)
    (!asyncMode && !rxFull) |=> (!rxReq && !rxDmaReq));
  assert_rx_off_R4: assert property (@(posedge clk) disable iff (rst)
    !rxIntEn |=> (!rxReq && !rxDmaReq));
  assert_brk_src_R5: assert property (@(posedge clk) disable iff (rst)
    ((rxIntEn || errIntEn) && (breakDet || overrun)) |=> brkReq);
  assert_err_via_rx_R6: assert property (@(posedge clk) disable iff (rst)
    (rxIntEn && rxError) |=> errReq);
  assert_rx_dma_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    rxToDma |=> !rxReq);
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!txReq && !rxReq && !errReq && !brkReq && !txDmaReq && !rxDmaReq
             && topSource == 3'd0));
endmodule

// File: tb/sim_sci_req_ctrl.sv
module sim_sci_req_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txEmpty = 0, rxFull = 0, dataReady = 0, rxError = 0, breakDet = 0, overrun = 0;
  logic txIntEn = 0, rxIntEn = 0, errIntEn = 0, asyncMode = 0, txToDma = 0, rxToDma = 0;
  logic txReq, rxReq, errReq, brkReq, txDmaReq, rxDmaReq;
  logic [2:0] topSource;

  typedef struct {
    logic [8:0] exp;
    string tag;
  } item_t;
  item_t sbq[$];

  int checks = 0;
  int errors = 0;
  bit driveDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sci_req_ctrl u0 (
    .clk(clk), .rst(rst), .txEmpty(txEmpty), .rxFull(rxFull), .dataReady(dataReady),
    .rxError(rxError), .breakDet(breakDet), .overrun(overrun), .txIntEn(txIntEn),
    .rxIntEn(rxIntEn), .errIntEn(errIntEn), .asyncMode(asyncMode), .txToDma(txToDma),
    .rxToDma(rxToDma), .txReq(txReq), .rxReq(rxReq), .errReq(errReq), .brkReq(brkReq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .topSource(topSource)
  );

  // flags = {txEmpty, rxFull, dataReady, rxError, breakDet, overrun}
  // en    = {txIntEn, rxIntEn, errIntEn}; dma = {txToDma, rxToDma}
  // Expected packing: {txReq, rxReq, errReq, brkReq, txDmaReq, rxDmaReq, topSource}
  function automatic logic [8:0] model(input logic r, input logic [5:0] f,
                                       input logic [2:0] en, input logic am,
                                       input logic [1:0] dma);
    logic tx, rx, er, bk, txc, rxc;
    logic [2:0] code;
    if (r) return 9'd0;
    tx  = en[2] && f[5];
    rx  = en[1] && (f[4] || (am && f[3]));
    er  = (en[1] || en[0]) && f[2];
    bk  = (en[1] || en[0]) && (f[1] || f[0]);
    txc = tx && !dma[1];
    rxc = rx && !dma[0];
    code = bk ? 3'd1 : er ? 3'd2 : rxc ? 3'd3 : txc ? 3'd4 : 3'd0;
    return {txc, rxc, er, bk, tx && dma[1], rx && dma[0], code};
  endfunction

  task automatic drive(input logic r, input logic [5:0] f, input logic [2:0] en,
                       input logic am, input logic [1:0] dma, input string tag);
    item_t it;
    @(negedge clk);
    rst = r;
    {txEmpty, rxFull, dataReady, rxError, breakDet, overrun} = f;
    {txIntEn, rxIntEn, errIntEn} = en;
    asyncMode = am;
    {txToDma, rxToDma} = dma;
    it.exp = model(r, f, en, am, dma);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: each posedge result belongs to the item driven on the prior negedge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        logic [8:0] act;
        it = sbq.pop_front();
        act = {txReq, rxReq, errReq, brkReq, txDmaReq, rxDmaReq, topSource};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    // R9: reset holds outputs low even with every source active
    drive(1, 6'b111111, 3'b111, 1, 2'b00, "R9 reset with all flags");
    drive(1, 6'b111111, 3'b111, 1, 2'b11, "R9 reset second cycle");
    drive(0, 6'b000000, 3'b000, 0, 2'b00, "R9 idle after reset");
    // R1 transmit
    drive(0, 6'b100000, 3'b100, 0, 2'b00, "R1 tx enabled");
    drive(0, 6'b100000, 3'b000, 0, 2'b00, "R1 tx disabled");
    drive(0, 6'b000000, 3'b100, 0, 2'b00, "R1 tx no flag");
    // R2 receive sources
    drive(0, 6'b010000, 3'b010, 0, 2'b00, "R2 rx full clocked");
    drive(0, 6'b001000, 3'b010, 1, 2'b00, "R2 data ready async");
    // R3 clocked mode ignores data ready
    drive(0, 6'b001000, 3'b010, 0, 2'b00, "R3 data ready clocked");
    drive(0, 6'b001000, 3'b010, 0, 2'b01, "R3 data ready clocked dma");
    // R4 error path alone
    drive(0, 6'b010111, 3'b001, 1, 2'b00, "R4 rx off err on");
    drive(0, 6'b011000, 3'b001, 1, 2'b01, "R4 rx off no fault");
    // R5 break sources
    drive(0, 6'b000010, 3'b001, 0, 2'b00, "R5 break only");
    drive(0, 6'b000001, 3'b001, 0, 2'b00, "R5 overrun only");
    drive(0, 6'b000100, 3'b001, 0, 2'b00, "R5 rx error only");
    drive(0, 6'b000111, 3'b100, 0, 2'b00, "R5 faults with path off");
    // R6 receive enable carries error path
    drive(0, 6'b000110, 3'b010, 0, 2'b00, "R6 rx enable err off");
    // R7 DMA steering
    drive(0, 6'b110000, 3'b110, 0, 2'b10, "R7 tx to dma");
    drive(0, 6'b110000, 3'b110, 0, 2'b01, "R7 rx to dma");
    drive(0, 6'b110111, 3'b111, 0, 2'b11, "R7 both dma faults stay cpu");
    // R8 priority
    drive(0, 6'b110000, 3'b110, 0, 2'b00, "R8 rx over tx");
    drive(0, 6'b110100, 3'b111, 0, 2'b00, "R8 err over rx");
    drive(0, 6'b111111, 3'b111, 1, 2'b00, "R8 brk over all");
    drive(0, 6'b110000, 3'b110, 0, 2'b01, "R8 dma rx not counted");
    drive(0, 6'b110000, 3'b110, 0, 2'b11, "R8 all dma none");
    // R10 back-to-back changes
    drive(0, 6'b100000, 3'b100, 0, 2'b00, "R10 step a");
    drive(0, 6'b000001, 3'b001, 0, 2'b00, "R10 step b");
    drive(0, 6'b100000, 3'b100, 0, 2'b00, "R10 step c");
    drive(1, 6'b111111, 3'b111, 1, 2'b00, "R9 mid-run reset");
    drive(0, 6'b000000, 3'b000, 0, 2'b00, "R10 final idle");
    driveDone = 1;
  end

  initial begin
    int cyc = 0;
    while (!(driveDone && sbq.size() == 0) && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    #2;
    if (cyc >= WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule